// File: doc/BRIEF.md
# ADC Channel Trigger Arbiter

This block decides which ADC input channel is converted next. Up to sixteen channels each carry a 4-bit source selector that ties the channel to one of a set of shared trigger sources: a one-shot software trigger, a level software trigger, a synchronous counter trigger, eleven external event inputs, or the scan trigger. A channel that selects the scan trigger joins a scan group when its membership mask bit is set. When the scan trigger fires, every member is queued and converted once, in ascending index order.

Each cycle, all live requests are collected, and the lowest channel index wins. The winning index is registered onto two select outputs. One drives the input analog multiplexer and the other drives the result demultiplexer. A grant also marks the converter busy. No further grant is issued until the converter stub pulses its done input.

A direct request that cannot be served waits in a single pending slot. If a newer request needs that slot, it overwrites the slot and the older request is lost. A sticky drop flag records every such loss, and a write-one-to-clear input resets the flag.

Top module: `adc_trig_arbiter`

## Requirements
- R1: The selector encoding is: 4'd0 none, 4'd1 one-shot software pin, 4'd2 level software pin, 4'd3 scan, 4'd4 synchronous pin, and 4'd5..4'd15 event pins 0..10. A non-scan source that fires requests only the channels selecting it.
- R2: A channel whose selector is 4'd0 is never granted, whatever the trigger pins do.
- R3: A channel whose index is not below `active_ch_cnt` is never granted, whatever its selector holds.
- R4: When several requests compete in one idle cycle, the lowest channel index is granted.
- R5: A direct request that is not granted waits in the pending slot. It is granted after the current conversion completes.
- R6: The pending slot holds one request. A newer request replaces the older one, and among same-cycle losers the lowest index is kept. Every request discarded this way sets `drop_flag`.
- R7: `drop_flag` is sticky. It is cleared by `drop_clr`=1, and a new loss in the same cycle wins over the clear.
- R8: The scan source is picked by `scan_src_sel` with the R1 encoding, except that 4'd3 means no trigger. A scan requests every enabled channel whose selector is 4'd3 and whose `scan_mask` bit is 1. Members are granted once each, in ascending order, one per conversion, and never set `drop_flag`.
- R9: A grant is registered. `grant_valid` pulses for one cycle in the cycle after the deciding cycle, `mux_sel` and `demux_sel` both carry the index and hold it until the next grant, and `busy` rises together with `grant_valid`. `busy` falls in the cycle after `conv_done`, and no grant is decided while `busy` is high. After reset all outputs are 0.
- R10: While the level software pin is held high, a channel selecting 4'd2 is granted again after each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active_ch_cnt | input | CNT_W | Number of enabled channels; higher indices are disabled |
| ch_src_sel | input | NUM_CH*4 | Per-channel source selector, channel k in bits [4k+3:4k] |
| scan_mask | input | NUM_CH | Scan membership, one bit per channel |
| scan_src_sel | input | 4 | Source that starts a scan |
| sw_single_trg | input | 1 | One-shot software trigger pulse |
| sw_level_trg | input | 1 | Level software trigger |
| sync_trg | input | 1 | Synchronous counter trigger pulse |
| evt_trg | input | NUM_EVT | External event trigger pulses |
| conv_done | input | 1 | Converter finished the current conversion |
| drop_clr | input | 1 | Write-one-to-clear for drop_flag |
| grant_valid | output | 1 | One-cycle grant strobe |
| mux_sel | output | CH_W | Analog input multiplexer select |
| demux_sel | output | CH_W | Result demultiplexer select |
| busy | output | 1 | Conversion in progress |
| drop_flag | output | 1 | Sticky lost-request flag |

## Verification
The bound checker checks properties on every cycle:
- a grant is decided only while idle, and it raises `busy`;
- `busy` falls after `conv_done`;
- the select outputs stay still between grants;
- `drop_flag` stays set until cleared;
- a granted channel never has a zero selector or an index at or above the active count.

Other behaviour is visible only through the bench's scenarios:
- lowest-index priority;
- which request survives in the pending slot and when `drop_flag` is set;
- the ascending order of a scan and its merging with direct requests;
- the repeated grants of the level trigger.

The bench computes these per episode from the configuration it drew.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SEL_W   = 4;
    localparam int NUM_EVT = 11;

    localparam logic [SEL_W-1:0] SRC_NONE   = 4'd0;
    localparam logic [SEL_W-1:0] SRC_SW_ONE = 4'd1;
    localparam logic [SEL_W-1:0] SRC_SW_LVL = 4'd2;
    localparam logic [SEL_W-1:0] SRC_SCAN   = 4'd3;
    localparam logic [SEL_W-1:0] SRC_SYNC   = 4'd4;
    localparam logic [SEL_W-1:0] SRC_EVT0   = 4'd5;

    // Whether the shared source named by sel is active this cycle.
    // The scan code never fires here; scan handling is separate.
    function automatic logic src_fires(
        input logic [SEL_W-1:0]   sel,
        input logic               sw_one,
        input logic               sw_lvl,
        input logic               sync,
        input logic [NUM_EVT-1:0] evt
    );
        logic hit;
        case (sel)
            SRC_NONE:   hit = 1'b0;
            SRC_SW_ONE: hit = sw_one;
            SRC_SW_LVL: hit = sw_lvl;
            SRC_SCAN:   hit = 1'b0;
            SRC_SYNC:   hit = sync;
            default:    hit = evt[int'(sel) - int'(SRC_EVT0)];
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/adc_trig_decode.sv
module adc_trig_decode
    import adc_trig_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0]        active_ch_cnt,
    input  logic [NUM_CH*SEL_W-1:0] ch_src_sel,
    input  logic [NUM_CH-1:0]       scan_mask,
    input  logic [SEL_W-1:0]        scan_src_sel,
    input  logic                    sw_single_trg,
    input  logic                    sw_level_trg,
    input  logic                    sync_trg,
    input  logic [NUM_EVT-1:0]      evt_trg,
    output logic [NUM_CH-1:0]       direct_req,
    output logic [NUM_CH-1:0]       scan_req
);

    logic scan_fire;

    // The reserved scan code decodes to no trigger inside src_fires.
    assign scan_fire = src_fires(scan_src_sel, sw_single_trg, sw_level_trg,
                                 sync_trg, evt_trg);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [SEL_W-1:0] sel;
        logic             en;
        assign sel = ch_src_sel[k*SEL_W +: SEL_W];
        assign en  = active_ch_cnt > CNT_W'(k);
        assign direct_req[k] = en && (sel != SRC_SCAN) &&
                               src_fires(sel, sw_single_trg, sw_level_trg,
                                         sync_trg, evt_trg);
        assign scan_req[k]   = en && (sel == SRC_SCAN) && scan_mask[k] &&
                               scan_fire;
    end

endmodule

// File: rtl/adc_trig_ffs.sv
module adc_trig_ffs #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter
    import adc_trig_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int CNT_W  = CH_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        active_ch_cnt,
    input  logic [NUM_CH*SEL_W-1:0] ch_src_sel,
    input  logic [NUM_CH-1:0]       scan_mask,
    input  logic [SEL_W-1:0]        scan_src_sel,
    input  logic                    sw_single_trg,
    input  logic                    sw_level_trg,
    input  logic                    sync_trg,
    input  logic [NUM_EVT-1:0]      evt_trg,
    input  logic                    conv_done,
    input  logic                    drop_clr,
    output logic                    grant_valid,
    output logic [CH_W-1:0]         mux_sel,
    output logic [CH_W-1:0]         demux_sel,
    output logic                    busy,
    output logic                    drop_flag
);

    typedef struct packed {
        logic              busy;
        logic              gnt;
        logic [CH_W-1:0]   sel;
        logic              slot_vld;
        logic [CH_W-1:0]   slot_ch;
        logic [NUM_CH-1:0] scan_rem;
        logic              drop;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_CH-1:0] direct_req, scan_req;
    logic [NUM_CH-1:0] slot_vec, cand, gbit, wait_vec, new_direct;
    logic              c_found, n_found, grant_now, lost;
    logic [CH_W-1:0]   c_idx, n_idx;

    adc_trig_decode #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_decode (
        .active_ch_cnt (active_ch_cnt),
        .ch_src_sel    (ch_src_sel),
        .scan_mask     (scan_mask),
        .scan_src_sel  (scan_src_sel),
        .sw_single_trg (sw_single_trg),
        .sw_level_trg  (sw_level_trg),
        .sync_trg      (sync_trg),
        .evt_trg       (evt_trg),
        .direct_req    (direct_req),
        .scan_req      (scan_req)
    );

    // Every request competing for the next grant.
    assign slot_vec = st_q.slot_vld ? (NUM_CH'(1) << st_q.slot_ch) : '0;
    assign cand     = direct_req | slot_vec | st_q.scan_rem | scan_req;

    adc_trig_ffs #(.N(NUM_CH), .IW(CH_W)) u_pick_grant (
        .vec   (cand),
        .found (c_found),
        .idx   (c_idx)
    );

    assign grant_now  = !st_q.busy && c_found;
    assign gbit       = grant_now ? (NUM_CH'(1) << c_idx) : '0;
    assign new_direct = direct_req & ~gbit;
    assign wait_vec   = (direct_req | slot_vec) & ~gbit;
    assign lost       = (wait_vec & (wait_vec - NUM_CH'(1))) != '0;

    // The lowest new loser claims the slot.
    adc_trig_ffs #(.N(NUM_CH), .IW(CH_W)) u_pick_slot (
        .vec   (new_direct),
        .found (n_found),
        .idx   (n_idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.gnt      = grant_now;
        st_d.scan_rem = (st_q.scan_rem | scan_req) & ~gbit;

        if (grant_now) begin
            st_d.sel  = c_idx;
            st_d.busy = 1'b1;
        end else if (st_q.busy && conv_done) begin
            st_d.busy = 1'b0;
        end

        if (n_found) begin
            st_d.slot_vld = 1'b1;
            st_d.slot_ch  = n_idx;
        end else if (st_q.slot_vld && !gbit[st_q.slot_ch]) begin
            st_d.slot_vld = 1'b1;
        end else begin
            st_d.slot_vld = 1'b0;
        end

        if (lost) begin
            st_d.drop = 1'b1;
        end else if (drop_clr) begin
            st_d.drop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gnt;
    assign mux_sel     = st_q.sel;
    assign demux_sel   = st_q.sel;
    assign busy        = st_q.busy;
    assign drop_flag   = st_q.drop;

endmodule

// File: rtl/adc_trig_arbiter_chk.sv
module adc_trig_arbiter_chk #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4,
    parameter int CNT_W  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CNT_W-1:0]    active_ch_cnt,
    input logic [NUM_CH*4-1:0] ch_src_sel,
    input logic                conv_done,
    input logic                drop_clr,
    input logic                grant_valid,
    input logic [CH_W-1:0]     mux_sel,
    input logic [CH_W-1:0]     demux_sel,
    input logic                busy,
    input logic                drop_flag
);

    function automatic logic [3:0] pick_sel(input logic [NUM_CH*4-1:0] v,
                                            input logic [CH_W-1:0] i);
        return v[int'(i)*4 +: 4];
    endfunction

    p_grant_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !$past(busy));

    p_busy_on_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> busy);

    p_busy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && conv_done |=> !busy);

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> $stable(mux_sel) && $stable(demux_sel));

    p_drop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag && !drop_clr |=> drop_flag);

    p_no_src_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pick_sel($past(ch_src_sel), mux_sel) != 4'd0);

    p_enabled_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> {1'b0, mux_sel} < $past(active_ch_cnt));

endmodule

bind adc_trig_arbiter adc_trig_arbiter_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .active_ch_cnt (active_ch_cnt),
    .ch_src_sel    (ch_src_sel),
    .conv_done     (conv_done),
    .drop_clr      (drop_clr),
    .grant_valid   (grant_valid),
    .mux_sel       (mux_sel),
    .demux_sel     (demux_sel),
    .busy          (busy),
    .drop_flag     (drop_flag)
);

// File: tb/adc_trig_arbiter_test.sv
`timescale 1ns/1ps
module adc_trig_arbiter_test;

    localparam int NCH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      active_ch_cnt = 5'd16;
    logic [NCH*4-1:0] ch_src_sel = '0;
    logic [NCH-1:0]  scan_mask = '0;
    logic [3:0]      scan_src_sel = 4'd0;
    logic            sw_single_trg = 1'b0, sw_level_trg = 1'b0, sync_trg = 1'b0;
    logic [10:0]     evt_trg = '0;
    logic            conv_done = 1'b0, drop_clr = 1'b0;
    logic            grant_valid, busy, drop_flag;
    logic [3:0]      mux_sel, demux_sel;

    int n_run = 0, n_fail = 0;
    int log_ch [0:63];
    int log_n = 0;
    int stub_lat = 2;
    int cnt = 0;

    always #10 clk = ~clk;

    adc_trig_arbiter uut (
        .clk(clk), .rst_n(rst_n), .active_ch_cnt(active_ch_cnt),
        .ch_src_sel(ch_src_sel), .scan_mask(scan_mask),
        .scan_src_sel(scan_src_sel), .sw_single_trg(sw_single_trg),
        .sw_level_trg(sw_level_trg), .sync_trg(sync_trg), .evt_trg(evt_trg),
        .conv_done(conv_done), .drop_clr(drop_clr),
        .grant_valid(grant_valid), .mux_sel(mux_sel), .demux_sel(demux_sel),
        .busy(busy), .drop_flag(drop_flag)
    );

    // Converter stub and grant logger, sampling away from the active edge.
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (!rst_n) begin
            cnt = 0;
        end else begin
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) conv_done = 1'b1;
            end
            if (grant_valid) begin
                if (log_n < 64) log_ch[log_n] = int'(mux_sel);
                log_n++;
                cnt = stub_lat;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(input int k, input logic [3:0] v);
        ch_src_sel[k*4 +: 4] = v;
    endtask

    task automatic clear_cfg();
        ch_src_sel = '0; scan_mask = '0; scan_src_sel = 4'd0;
        active_ch_cnt = 5'd16; log_n = 0;
        drop_clr = 1'b1; run(1); drop_clr = 1'b0;
    endtask

    // Drive the pin behind source code s for one cycle.
    task automatic pulse_src(input int s);
        if (s == 1) sw_single_trg = 1'b1;
        else if (s == 4) sync_trg = 1'b1;
        else if (s >= 5) evt_trg[s-5] = 1'b1;
        run(1);
        sw_single_trg = 1'b0; sync_trg = 1'b0; evt_trg = '0;
    endtask

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) if (m[i]) c++;
        return c;
    endfunction

    // Compare the logged grants against the ascending members of m.
    task automatic check_log(input string tag, input logic [15:0] m);
        int j = 0;
        check({tag, " grant count"}, log_n, popc(m));
        for (int i = 0; i < 16; i++) begin
            if (m[i] && j < log_n) begin
                check({tag, " grant order"}, log_ch[j], i);
                j++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_71a3));
        run(3);
        // R9 reset values
        check("R9 reset grant_valid", int'(grant_valid), 0);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset mux_sel", int'(mux_sel), 0);
        check("R7 reset drop_flag", int'(drop_flag), 0);
        rst_n = 1'b1;
        run(2);

        // R1 and R9: synchronous source, grant timing and both selects
        clear_cfg();
        set_src(5, 4'd4);
        sync_trg = 1'b1; run(1); sync_trg = 1'b0;
        check("R9 grant strobe", int'(grant_valid), 1);
        check("R9 mux_sel", int'(mux_sel), 5);
        check("R9 demux_sel", int'(demux_sel), 5);
        check("R9 busy on grant", int'(busy), 1);
        run(1);
        check("R9 strobe one cycle", int'(grant_valid), 0);
        run(4);
        check("R9 busy released", int'(busy), 0);
        check("R9 select held", int'(mux_sel), 5);

        // R4 and R5: two same-cycle requests, loser served after done
        clear_cfg();
        set_src(9, 4'd1); set_src(3, 4'd1);
        pulse_src(1); run(20);
        check_log("R4 R5 pair", 16'h0208);
        check("R5 no drop for pair", int'(drop_flag), 0);

        // R6: three same-cycle requests, the highest is lost
        clear_cfg();
        set_src(2, 4'd1); set_src(7, 4'd1); set_src(12, 4'd1);
        pulse_src(1); run(20);
        check_log("R6 triple", 16'h0084);
        check("R6 drop set", int'(drop_flag), 1);
        run(5);
        check("R7 drop sticky", int'(drop_flag), 1);
        drop_clr = 1'b1; run(1); drop_clr = 1'b0;
        check("R7 drop cleared", int'(drop_flag), 0);

        // R6 and R1: newer event request overwrites the slot while busy
        clear_cfg();
        stub_lat = 6;
        set_src(1, 4'd5); set_src(4, 4'd6); set_src(6, 4'd7);
        evt_trg[0] = 1'b1; run(1); evt_trg = '0;
        evt_trg[1] = 1'b1; run(1); evt_trg = '0;
        evt_trg[2] = 1'b1; run(1); evt_trg = '0;
        run(30);
        check_log("R6 overwrite", 16'h0042);
        check("R6 overwrite drop", int'(drop_flag), 1);
        stub_lat = 2;

        // R2: a zero selector ignores every pin
        clear_cfg();
        set_src(8, 4'd1);
        sw_single_trg = 1'b1; sync_trg = 1'b1; evt_trg = '1; sw_level_trg = 1'b1;
        run(1);
        sw_single_trg = 1'b0; sync_trg = 1'b0; evt_trg = '0; sw_level_trg = 1'b0;
        run(20);
        check_log("R2 zero selector", 16'h0100);

        // R3: indices at or above the active count are disabled
        clear_cfg();
        active_ch_cnt = 5'd4;
        set_src(6, 4'd1); set_src(2, 4'd1);
        pulse_src(1); run(20);
        check_log("R3 disabled channel", 16'h0004);

        // R8: scan in ascending order, non-members and other sources excluded
        clear_cfg();
        scan_src_sel = 4'd4;
        set_src(1, 4'd3); set_src(3, 4'd3); set_src(10, 4'd3); set_src(5, 4'd3);
        set_src(7, 4'd1);
        scan_mask = 16'h048A;
        pulse_src(4); run(40);
        check_log("R8 scan", 16'h040A);
        check("R8 scan no drop", int'(drop_flag), 0);

        // R8: reserved scan source never fires
        log_n = 0;
        scan_src_sel = 4'd3;
        sw_single_trg = 1'b1; sync_trg = 1'b1; evt_trg = '1;
        run(1);
        sw_single_trg = 1'b0; sync_trg = 1'b0; evt_trg = '0;
        run(20);
        check("R8 reserved scan source", log_n, 1);

        // R10: level trigger repeats while high
        clear_cfg();
        set_src(4, 4'd2);
        sw_level_trg = 1'b1; run(20); sw_level_trg = 1'b0;
        run(20);
        n_run++;
        if (log_n < 3 || log_n > 7) begin
            n_fail++;
            $display("FAIL R10 burst count actual=%0d expected=3..7", log_n);
        end
        for (int i = 0; i < log_n && i < 64; i++)
            check("R10 burst channel", log_ch[i], 4);

        // Random episodes: direct and scan requests on one shared source
        for (int ep = 0; ep < 60; ep++) begin
            int r, s, c, g, keep_d;
            logic [15:0] en_m, scan_m, dir_m, kept, rest;
            clear_cfg();
            r = $urandom_range(0, 12);
            s = (r == 0) ? 1 : (r == 1) ? 4 : r + 3;
            c = $urandom_range(1, 16);
            active_ch_cnt = 5'(c);
            scan_src_sel = 4'(s);
            stub_lat = $urandom_range(1, 4);
            scan_mask = 16'($urandom);
            en_m = 16'((32'd1 << c) - 1);
            scan_m = '0; dir_m = '0;
            for (int k = 0; k < 16; k++) begin
                int v = $urandom_range(0, 3);
                set_src(k, (v == 0) ? 4'd0 : (v == 1) ? 4'd2 :
                           (v == 2) ? 4'd3 : 4'(s));
                if (v == 2 && scan_mask[k] && en_m[k]) scan_m[k] = 1'b1;
                if (v == 3 && en_m[k]) dir_m[k] = 1'b1;
            end
            g = lowest(dir_m | scan_m);
            kept = scan_m;
            rest = dir_m;
            if (rest != 0) begin
                kept[lowest(rest)] = 1'b1; rest[lowest(rest)] = 1'b0;
            end
            if (g >= 0 && dir_m[g] && rest != 0) begin
                kept[lowest(rest)] = 1'b1; rest[lowest(rest)] = 1'b0;
            end
            keep_d = popc(dir_m) - popc(rest);
            pulse_src(s);
            run(150);
            check_log("R4 R6 R8 random", kept);
            check("R6 random drop", int'(drop_flag),
                  (popc(dir_m) > keep_d) ? 1 : 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule